// File: doc/BRIEF.md
# Operand Bypass Latency Scoreboard

This block records, for every architectural register, how long ago its most recent producer issued and which pipe produced it. Issue logic asks whether a source register may be read by an instruction headed for a given pipe in the current cycle. The block answers ready or not-ready for that consumer. The required distance depends on the producing pipe, the consuming pipe and the op class of the producer.

One producer is reported per cycle with a destination register, a pipe code and an op class. Each entry keeps a down-counter that is loaded with the worst-case distance minus one and then counts down. A query compares the counter against a small slack. The slack is wider for a consumer on the fast path, such as a same-pipe self-bypass or a load feeding the integer side. Several query ports read the table at once.

Top module: `operand_ready_sb`

## Requirements
- R1: After reset every register reports ready to every consumer pipe.
- R2: A simple op result (class code 0) is ready to a consumer in the same pipe in the first cycle after the issue cycle (distance 1). Pipe codes are FX1=0, FX2=1, LS1=2, LS2=3, VS=4, and the load/store pipes also run simple ops.
- R3: A simple op result is ready to a consumer in any other pipe at distance 2, and is not ready at distance 1.
- R4: A load (class code 1) is ready at distance 2 to consumers in FX1, FX2, LS1 and LS2, and at distance 3 to a VS consumer.
- R5: A multiply (class code 2) is ready at distance 4 in the same pipe and at distance 5 in another pipe.
- R6: A 32-bit divide (class code 3) is ready at distance 36 same-pipe and 37 cross-pipe. A 64-bit divide (class code 4) is ready at distance 68 and 69 respectively.
- R7: A newer producer to a register replaces the older entry, so readiness then follows the newer producer's class and pipe only.
- R8: A query for a register that is written in the same cycle returns not-ready on every query port, whatever the register's prior state.
- R9: A write to one register does not change the readiness of any other register, and each query port answers independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | A producer issues this cycle |
| wr_reg_i | input | REG_W | Destination register of the producer |
| wr_pipe_i | input | 3 | Producing pipe code |
| wr_op_i | input | 3 | Producer op class code |
| q_reg_i | input | NUM_QRY x REG_W | Source register per query port |
| q_pipe_i | input | NUM_QRY x 3 | Consumer pipe code per query port |
| q_rdy_o | output | NUM_QRY | Source usable this cycle, per query port |

## Verification
The answer is combinational from the stored table and the inputs of the current cycle. A producer issued in cycle t therefore affects a query in cycle t itself, where it must read not-ready, and in every cycle t+k after it. Readiness is due exactly at cycle t+d, where d is the class and pipe distance from R2 to R6. The bench drives a producer at one falling edge and presents the query at each following falling edge. It samples one time unit later, so the distance k equals the number of rising edges since the write. It expects not-ready for every k below d and ready at d and d+1.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [2:0] {
    PIPE_FX1 = 3'd0,
    PIPE_FX2 = 3'd1,
    PIPE_LS1 = 3'd2,
    PIPE_LS2 = 3'd3,
    PIPE_VS  = 3'd4
  } pipe_e;

  typedef enum logic [2:0] {
    OP_SIMPLE = 3'd0,
    OP_LOAD   = 3'd1,
    OP_MUL    = 3'd2,
    OP_DIV32  = 3'd3,
    OP_DIV64  = 3'd4
  } op_e;

  localparam int PIPE_W = 3;
  localparam int OP_W   = 3;
endpackage

// File: rtl/sb_lat_calc.sv
module sb_lat_calc
  import sb_pkg::*;
#(
  parameter int CNT_W      = 7,
  parameter int LAT_SIMPLE = 1,
  parameter int LAT_MUL    = 4,
  parameter int LAT_DIV32  = 36,
  parameter int LAT_DIV64  = 68,
  parameter int LAT_LD_VS  = 3
) (
  input  logic [OP_W-1:0]  op_i,
  output logic [CNT_W-1:0] init_o,
  output logic             is_load_o
);
  // init = worst-case distance - 1; non-load worst case is cross pipe = LAT + 1
  always_comb begin
    is_load_o = 1'b0;
    case (op_i)
      OP_LOAD: begin
        init_o    = CNT_W'(LAT_LD_VS - 1);
        is_load_o = 1'b1;
      end
      OP_MUL:   init_o = CNT_W'(LAT_MUL);
      OP_DIV32: init_o = CNT_W'(LAT_DIV32);
      OP_DIV64: init_o = CNT_W'(LAT_DIV64);
      default:  init_o = CNT_W'(LAT_SIMPLE);
    endcase
  end
endmodule

// File: rtl/sb_entry.sv
module sb_entry
  import sb_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  init_i,
  input  logic [PIPE_W-1:0] pipe_i,
  input  logic              is_load_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [PIPE_W-1:0] pipe_o,
  output logic              is_load_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= '0;
      pipe_o    <= '0;
      is_load_o <= 1'b0;
    end else if (load_i) begin
      cnt_o     <= init_i;
      pipe_o    <= pipe_i;
      is_load_o <= is_load_i;
    end else if (cnt_o != '0) begin
      cnt_o <= cnt_o - 1'b1;
    end
  end

  AST_LOAD_REPLACES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_o == $past(init_i)) && (pipe_o == $past(pipe_i))); // R7
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1'b1); // R6
  AST_COUNT_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_o == '0) |=> cnt_o == '0); // R1
endmodule

// File: rtl/sb_query.sv
module sb_query
  import sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int CNT_W    = 7,
  parameter int LD_SLACK = 1,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_REGS-1:0][CNT_W-1:0]    cnt_i,
  input  logic [NUM_REGS-1:0][PIPE_W-1:0]   pipe_i,
  input  logic [NUM_REGS-1:0]               ld_i,
  input  logic                              wr_valid_i,
  input  logic [REG_W-1:0]                  wr_reg_i,
  input  logic [REG_W-1:0]                  q_reg_i,
  input  logic [PIPE_W-1:0]                 q_pipe_i,
  output logic                              rdy_o
);
  logic [CNT_W-1:0]  sel_cnt;
  logic [PIPE_W-1:0] sel_pipe;
  logic              sel_ld;
  logic [CNT_W-1:0]  slack;
  logic              wr_hit;

  assign sel_cnt  = cnt_i[q_reg_i];
  assign sel_pipe = pipe_i[q_reg_i];
  assign sel_ld   = ld_i[q_reg_i];
  assign wr_hit   = wr_valid_i && (wr_reg_i == q_reg_i);

  // fast path gets one more cycle of slack against the worst-case counter
  always_comb begin
    if (sel_ld) slack = (q_pipe_i == PIPE_VS) ? '0 : CNT_W'(LD_SLACK);
    else        slack = (q_pipe_i == sel_pipe) ? CNT_W'(1) : '0;
  end

  assign rdy_o = !wr_hit && (sel_cnt <= slack);

  AST_WRITE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |-> !rdy_o); // R8
endmodule

// File: rtl/operand_ready_sb.sv
module operand_ready_sb
  import sb_pkg::*;
#(
  parameter int NUM_REGS   = 32,
  parameter int NUM_QRY    = 2,
  parameter int LAT_SIMPLE = 1,
  parameter int LAT_MUL    = 4,
  parameter int LAT_DIV32  = 36,
  parameter int LAT_DIV64  = 68,
  parameter int LAT_LD_FX  = 2,
  parameter int LAT_LD_VS  = 3,
  localparam int REG_W     = $clog2(NUM_REGS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_valid_i,
  input  logic [REG_W-1:0]               wr_reg_i,
  input  logic [2:0]                     wr_pipe_i,
  input  logic [2:0]                     wr_op_i,
  input  logic [NUM_QRY-1:0][REG_W-1:0]  q_reg_i,
  input  logic [NUM_QRY-1:0][2:0]        q_pipe_i,
  output logic [NUM_QRY-1:0]             q_rdy_o
);
  localparam int MAX_A   = (LAT_DIV64 > LAT_DIV32) ? LAT_DIV64 : LAT_DIV32;
  localparam int MAX_B   = (LAT_MUL > LAT_SIMPLE) ? LAT_MUL : LAT_SIMPLE;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CNT = (MAX_AB > LAT_LD_VS - 1) ? MAX_AB : LAT_LD_VS - 1;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam int LD_SLACK = LAT_LD_VS - LAT_LD_FX;

  logic [CNT_W-1:0]                  init_cnt;
  logic                              init_ld;
  logic [NUM_REGS-1:0][CNT_W-1:0]    cnt;
  logic [NUM_REGS-1:0][PIPE_W-1:0]   pipe;
  logic [NUM_REGS-1:0]               ld;

  sb_lat_calc #(
    .CNT_W(CNT_W), .LAT_SIMPLE(LAT_SIMPLE), .LAT_MUL(LAT_MUL),
    .LAT_DIV32(LAT_DIV32), .LAT_DIV64(LAT_DIV64), .LAT_LD_VS(LAT_LD_VS)
  ) i_lat (
    .op_i     (wr_op_i),
    .init_o   (init_cnt),
    .is_load_o(init_ld)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    sb_entry #(.CNT_W(CNT_W)) i_entry (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (wr_valid_i && (wr_reg_i == REG_W'(g))),
      .init_i   (init_cnt),
      .pipe_i   (wr_pipe_i),
      .is_load_i(init_ld),
      .cnt_o    (cnt[g]),
      .pipe_o   (pipe[g]),
      .is_load_o(ld[g])
    );
  end

  for (genvar q = 0; q < NUM_QRY; q++) begin : g_query
    sb_query #(
      .NUM_REGS(NUM_REGS), .CNT_W(CNT_W), .LD_SLACK(LD_SLACK)
    ) i_query (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_i     (cnt),
      .pipe_i    (pipe),
      .ld_i      (ld),
      .wr_valid_i(wr_valid_i),
      .wr_reg_i  (wr_reg_i),
      .q_reg_i   (q_reg_i[q]),
      .q_pipe_i  (q_pipe_i[q]),
      .rdy_o     (q_rdy_o[q])
    );
  end
endmodule

// File: tb/test_operand_ready_sb.sv
module test_operand_ready_sb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // {producer pipe, op class, consumer pipe, distance}
  localparam logic [15:0] VEC [NV] = '{
    {3'd0, 3'd0, 3'd0, 7'd1},
    {3'd0, 3'd0, 3'd1, 7'd2},
    {3'd2, 3'd0, 3'd2, 7'd1},
    {3'd3, 3'd0, 3'd0, 7'd2},
    {3'd4, 3'd0, 3'd4, 7'd1},
    {3'd2, 3'd1, 3'd1, 7'd2},
    {3'd3, 3'd1, 3'd3, 7'd2},
    {3'd2, 3'd1, 3'd4, 7'd3},
    {3'd1, 3'd2, 3'd1, 7'd4},
    {3'd0, 3'd2, 3'd1, 7'd5},
    {3'd0, 3'd3, 3'd0, 7'd36},
    {3'd1, 3'd3, 3'd0, 7'd37},
    {3'd1, 3'd4, 3'd1, 7'd68},
    {3'd0, 3'd4, 3'd1, 7'd69}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_valid = 1'b0;
  logic [4:0] wr_reg = '0;
  logic [2:0] wr_pipe = '0;
  logic [2:0] wr_op = '0;
  logic [1:0][4:0] q_reg = '0;
  logic [1:0][2:0] q_pipe = '0;
  logic [1:0] q_rdy;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  operand_ready_sb i_operand_ready_sb (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid), .wr_reg_i(wr_reg),
    .wr_pipe_i(wr_pipe), .wr_op_i(wr_op), .q_reg_i(q_reg), .q_pipe_i(q_pipe),
    .q_rdy_o(q_rdy)
  );

  task automatic check(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", what, got, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] op, input logic [2:0] pp,
                                   input logic [2:0] cp);
    case (op)
      3'd1:      return "R4";
      3'd2:      return "R5";
      3'd3, 3'd4: return "R6";
      default:   return (pp == cp) ? "R2" : "R3";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: all registers ready after reset, various consumer pipes
    for (int r = 0; r < 32; r += 2) begin
      @(negedge clk);
      q_reg[0] = 5'(r); q_reg[1] = 5'(r + 1);
      q_pipe[0] = 3'(r % 5); q_pipe[1] = 3'((r + 3) % 5);
      #1;
      check(q_rdy[0], 1'b1, $sformatf("R1 reset reg %0d", r));
      check(q_rdy[1], 1'b1, $sformatf("R1 reset reg %0d", r + 1));
    end

    // table of distances, one fresh register per vector
    for (int v = 0; v < NV; v++) begin
      logic [2:0] pp, op, cp;
      int d;
      string tag;
      {pp, op, cp} = VEC[v][15:7];
      d = int'(VEC[v][6:0]);
      tag = req_of(op, pp, cp);
      @(negedge clk);
      wr_valid = 1'b1; wr_reg = 5'(v + 1); wr_pipe = pp; wr_op = op;
      q_reg[0] = 5'(v + 1); q_pipe[0] = cp;
      q_reg[1] = 5'd0; q_pipe[1] = cp;
      #1;
      check(q_rdy[0], 1'b0, $sformatf("R8 vec %0d same-cycle query", v));
      for (int k = 1; k <= d + 1; k++) begin
        @(negedge clk);
        wr_valid = 1'b0;
        #1;
        check(q_rdy[0], (k >= d), $sformatf("%s vec %0d distance %0d", tag, v, k));
        check(q_rdy[1], 1'b1, $sformatf("R9 vec %0d other reg distance %0d", v, k));
      end
    end

    // R7: long divide overwritten by a simple op
    @(negedge clk);
    wr_valid = 1'b1; wr_reg = 5'd20; wr_pipe = 3'd0; wr_op = 3'd4;
    @(negedge clk);
    wr_reg = 5'd20; wr_pipe = 3'd1; wr_op = 3'd0;
    q_reg[0] = 5'd20; q_pipe[0] = 3'd1;
    q_reg[1] = 5'd20; q_pipe[1] = 3'd0;
    #1;
    check(q_rdy[0], 1'b0, "R8 port0 overwrite cycle");
    check(q_rdy[1], 1'b0, "R8 port1 overwrite cycle");
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
    check(q_rdy[0], 1'b1, "R7 newer simple op same pipe distance 1");
    check(q_rdy[1], 1'b0, "R7 newer simple op cross pipe distance 1");
    @(negedge clk);
    #1;
    check(q_rdy[1], 1'b1, "R7 newer simple op cross pipe distance 2");

    // R9: pending divide on one register, neighbour stays ready
    @(negedge clk);
    wr_valid = 1'b1; wr_reg = 5'd25; wr_pipe = 3'd0; wr_op = 3'd3;
    q_reg[0] = 5'd26; q_pipe[0] = 3'd0;
    #1;
    check(q_rdy[0], 1'b1, "R9 neighbour during write");
    @(negedge clk);
    wr_valid = 1'b0;
    q_reg[1] = 5'd25; q_pipe[1] = 3'd0;
    #1;
    check(q_rdy[0], 1'b1, "R9 neighbour after write");
    check(q_rdy[1], 1'b0, "R9 written reg pending");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule